// File: doc/BRIEF.md
# Nine-Bit Asynchronous Frame Transmitter

This block serialises one byte plus a ninth, software-chosen bit into an 11-bit asynchronous frame on a single output line. Each frame has a low start bit, the eight data bits with bit 0 first, the ninth bit, and a high stop bit. A processor-side write strobe loads the byte and the ninth-bit value. The block then raises a completion flag that stays set until software clears it with a pulse.

Bit timing comes from a free-running divide-by-16 counter. An oversampling tick advances that counter. The tick is either generated inside the block from the core clock or taken from an external tick input. A frame never starts on the write strobe itself. It starts at the next wrap of the counter, so every bit edge falls on a counter wrap.

The end of a frame is found from the shift register's own contents. On the first shift, a one marker enters behind the data, and zeros follow it on every later shift. The frame ends when the marker sits one place above the output position and every place above it is zero. No bit counter is needed.

Top module: `ninebit_frame_tx`

## Requirements
- R1: A frame on `txd` is, in time order: a 0 start bit, `wr_data[0]` through `wr_data[7]`, `wr_ninth`, then a 1 stop bit. Each bit lasts one bit time.
- R2: While no frame is being sent (`sending` low), `txd` is 1.
- R3: An accepted write starts its frame at the first wrap of the divide-by-16 counter that comes after the write cycle. The start edge therefore follows the write by at least 2 and at most one bit time plus 1 clock cycles. Within one rate setting, start edges of different frames are a whole number of bit times apart.
- R4: With `fixed_rate`=1, the internal tick runs at core clock / 2 when `rate_sel`=1, giving a bit time of 32 clocks. It runs at core clock / 4 when `rate_sel`=0, giving 64 clocks.
- R5: With `fixed_rate`=0, one bit time is 16 pulses of `ext_tick`.
- R6: `ti` rises, and `sending` falls, on the same clock edge as the start of the stop bit. That edge is exactly 10 bit times after the start edge. `ti` is 0 during the ninth-bit slot when it was cleared before the frame.
- R7: Once set, `ti` stays 1 until a one-cycle `ti_clr` pulse. After the pulse it reads 0 in the following cycle, provided no frame ends in that cycle.
- R8: A write made while a frame is pending or in flight is ignored. The current frame goes out unchanged, and no extra frame follows.
- R9: After reset, `txd`=1, `ti`=0 and `sending`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fixed_rate | input | 1 | 1: internal tick from core clock; 0: use `ext_tick` |
| rate_sel | input | 1 | Internal tick rate: 1 = clock/2, 0 = clock/4 |
| ext_tick | input | 1 | External 16x-baud tick, one cycle wide |
| wr_en | input | 1 | Write strobe for data and ninth bit |
| wr_data | input | 8 | Data byte, sent LSB first |
| wr_ninth | input | 1 | Value of the ninth frame bit |
| ti_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial output line |
| ti | output | 1 | Transmit-done flag |
| sending | output | 1 | High from start bit until the stop bit begins |

## Verification
The checker asserts on every cycle that the line idles high and that `txd` changes during a frame only on a counter wrap. It also checks that a frame starts only on a wrap and starts low, that `ti` is set whenever the frame ends, that `ti` holds until cleared, and that a write during a frame leaves the shift register untouched. Other properties can only be shown by the bench's scenarios. These are: bit order and ninth-bit value across several data patterns, including a byte whose raw contents look like the end pattern; exact bit lengths in the three rate settings; the ten-bit-time distance from start to `ti`; and the absence of any extra frame after ignored writes.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2
  } ftx_phase_e;
endpackage

// File: rtl/ftx_rst_sync.sv
module ftx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ftx_bit_clock.sv
// Oversampling tick source and free-running divide-by-OVS counter.
module ftx_bit_clock #(
  parameter int OVS      = 16,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fixed_rate,
  input  logic rate_sel,
  input  logic ext_tick,
  output logic roll
);
  localparam int CNT_W = $clog2(OVS);
  localparam int PRE_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [CNT_W-1:0] div_q, div_d;
  logic             pre_wrap, tick;

  assign pre_lim  = rate_sel ? PRE_W'(FAST_DIV - 1) : PRE_W'(SLOW_DIV - 1);
  assign pre_wrap = (pre_q >= pre_lim);
  assign pre_d    = pre_wrap ? '0 : pre_q + PRE_W'(1);
  assign tick     = fixed_rate ? pre_wrap : ext_tick;

  generate
    if ((OVS & (OVS - 1)) == 0) begin : g_pow2_wrap
      assign div_d = tick ? div_q + CNT_W'(1) : div_q;
    end else begin : g_cmp_wrap
      assign div_d = !tick ? div_q :
                     (div_q == CNT_W'(OVS - 1)) ? '0 : div_q + CNT_W'(1);
    end
  endgenerate

  assign roll = tick && (div_q == CNT_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/ftx_shifter.sv
// Transmit shift register with zero-fill end-of-frame pattern detect.
module ftx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_ninth,
  input  logic              shift,
  input  logic              marker_in,
  output logic              ser_bit,
  output logic              last_seen,
  output logic [DATA_W:0]   sh_vec
);
  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = {load_ninth, load_data};
    else if (shift) sh_d = {marker_in, sh_q[SH_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // Marker one place above the output, only zeros above the marker.
  assign last_seen = sh_q[1] && (sh_q[SH_W-1:2] == '0);
  assign ser_bit   = sh_q[0];
  assign sh_vec    = sh_q;
endmodule

// File: rtl/ftx_ctrl.sv
// Request, phase sequencing and done flag.
module ftx_ctrl
  import ftx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       roll,
  input  logic       wr_en,
  input  logic       ti_clr,
  input  logic       last_seen,
  output logic       load,
  output logic       shift,
  output logic       marker,
  output ftx_phase_e phase,
  output logic       ti
);
  ftx_phase_e phase_q, phase_d;
  logic       req_q, req_d;
  logic       armed_q, armed_d;
  logic       ti_q, ti_d;
  logic       set_ti;

  always_comb begin
    phase_d = phase_q;
    req_d   = req_q;
    armed_d = armed_q;
    load    = 1'b0;
    shift   = 1'b0;
    marker  = 1'b0;
    set_ti  = 1'b0;
    if (wr_en && !req_q && (phase_q == PH_IDLE)) begin
      load  = 1'b1;
      req_d = 1'b1;
    end
    if (roll) begin
      case (phase_q)
        PH_IDLE: begin
          if (req_q) begin
            phase_d = PH_START;
            req_d   = 1'b0;
          end
        end
        PH_START: begin
          phase_d = PH_DATA;
          armed_d = 1'b0;
        end
        PH_DATA: begin
          shift   = 1'b1;
          marker  = !armed_q;
          armed_d = 1'b1;
          if (armed_q && last_seen) begin
            phase_d = PH_IDLE;
            set_ti  = 1'b1;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
    if (set_ti)      ti_d = 1'b1;
    else if (ti_clr) ti_d = 1'b0;
    else             ti_d = ti_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      req_q   <= 1'b0;
      armed_q <= 1'b0;
      ti_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      req_q   <= req_d;
      armed_q <= armed_d;
      ti_q    <= ti_d;
    end
  end

  assign phase = phase_q;
  assign ti    = ti_q;
endmodule

// File: rtl/ninebit_frame_tx.sv
module ninebit_frame_tx
  import ftx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed_rate,
  input  logic              rate_sel,
  input  logic              ext_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  input  logic              ti_clr,
  output logic              txd,
  output logic              ti,
  output logic              sending
);
  logic            rst_sync_n;
  logic            roll;
  logic            load, shift, marker;
  logic            ser_bit, last_seen;
  logic [DATA_W:0] sh_vec;
  ftx_phase_e      phase;

  ftx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  ftx_bit_clock #(.OVS(OVS), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_sync_n), .fixed_rate(fixed_rate),
    .rate_sel(rate_sel), .ext_tick(ext_tick), .roll(roll)
  );

  ftx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .load_data(wr_data),
    .load_ninth(wr_ninth), .shift(shift), .marker_in(marker),
    .ser_bit(ser_bit), .last_seen(last_seen), .sh_vec(sh_vec)
  );

  ftx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .roll(roll), .wr_en(wr_en),
    .ti_clr(ti_clr), .last_seen(last_seen), .load(load), .shift(shift),
    .marker(marker), .phase(phase), .ti(ti)
  );

  always_comb begin
    case (phase)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = ser_bit;
      default:  txd = 1'b1;
    endcase
  end

  assign sending = (phase != PH_IDLE);
endmodule

// File: rtl/ftx_checker.sv
module ftx_checker #(
  parameter int SH_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            roll,
  input logic            sending,
  input logic            txd,
  input logic            ti,
  input logic            ti_clr,
  input logic            wr_en,
  input logic [SH_W-1:0] sh
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sending |-> txd);

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> !txd);

  p_start_on_roll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> $past(roll));

  p_bit_edges_on_roll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !roll) |=> $stable(txd));

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sending) |-> (ti && $past(roll)));

  p_ti_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ti_clr) |=> ti);

  p_ti_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ti_clr && !sending) |=> !ti);

  p_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && wr_en && !roll) |=> $stable(sh));
endmodule

bind ninebit_frame_tx ftx_checker #(.SH_W(DATA_W + 1)) u_ftx_chk (
  .clk(clk), .rst_n(rst_sync_n), .roll(roll), .sending(sending),
  .txd(txd), .ti(ti), .ti_clr(ti_clr), .wr_en(wr_en), .sh(sh_vec)
);

// File: tb/tb_ninebit_frame_tx.sv
module tb_ninebit_frame_tx;
  logic       clk, rst_n;
  logic       fixed_rate, rate_sel, ext_tick;
  logic       wr_en, wr_ninth, ti_clr;
  logic [7:0] wr_data;
  logic       txd, ti, sending;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int bit_clks = 32;
  int ext_div  = 3;
  bit ext_on   = 0;
  bit rst_done = 0;
  int mon_start = 0;
  int align_ref = 0;
  bit align_ok  = 0;
  logic [8:0] exp_q [$];

  ninebit_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .fixed_rate(fixed_rate), .rate_sel(rate_sel),
    .ext_tick(ext_tick), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ninth(wr_ninth), .ti_clr(ti_clr), .txd(txd), .ti(ti),
    .sending(sending)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "WATCHDOG", "run did not complete", 0, 1);
    finish_run();
  end

  // External tick source.
  initial begin
    int cnt;
    cnt = 0;
    ext_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (ext_on) begin
        if (cnt == ext_div - 1) begin ext_tick = 1'b1; cnt = 0; end
        else begin ext_tick = 1'b0; cnt++; end
      end else begin
        ext_tick = 1'b0;
        cnt = 0;
      end
    end
  end

  // Monitor: recovers frames from txd, compares with the scoreboard queue.
  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_done && prev && !txd) begin
        int st;
        logic [10:0] rx;
        logic ti_pre;
        logic [8:0] e;
        logic [10:0] ef;
        ti_pre = 1'b0;
        st = cyc;
        mon_start = st;
        if (align_ok)
          check(((st - align_ref) % bit_clks) == 0, "R3",
                "start edge off bit grid", (st - align_ref) % bit_clks, 0);
        else begin
          align_ref = st;
          align_ok = 1;
        end
        repeat (bit_clks / 2) @(negedge clk);
        rx[0] = txd;
        for (int i = 1; i < 11; i++) begin
          repeat (bit_clks) @(negedge clk);
          rx[i] = txd;
          if (i == 9) ti_pre = ti;
        end
        check(ti_pre == 1'b0, "R6", "ti during ninth-bit slot", ti_pre, 0);
        check(ti == 1'b1, "R6", "ti during stop bit", ti, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected extra frame", rx, 0);
        end else begin
          e  = exp_q.pop_front();
          ef = {1'b1, e[8], e[7:0], 1'b0};
          check(rx == ef, "R1", "frame bits (LSB=start)", rx, ef);
        end
      end
      prev = txd;
    end
  end

  task automatic pulse_wr(input logic [7:0] d, input logic n);
    @(negedge clk);
    wr_data = d; wr_ninth = n; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_ti();
    @(negedge clk);
    ti_clr = 1'b1;
    @(negedge clk);
    ti_clr = 1'b0;
    check(ti == 1'b0, "R7", "ti after clear pulse", ti, 0);
  endtask

  // Driver: posts the expected item, writes, waits for done, checks timing.
  task automatic send_frame(input logic [7:0] d, input logic n, input bit do_clear);
    int wc, tc;
    exp_q.push_back({n, d});
    @(negedge clk);
    wr_data = d; wr_ninth = n; wr_en = 1'b1;
    wc = cyc;
    @(negedge clk);
    wr_en = 1'b0;
    while (!ti) @(negedge clk);
    tc = cyc;
    check((mon_start - wc) >= 2 && (mon_start - wc) <= bit_clks + 1, "R3",
          "write-to-start latency", mon_start - wc, bit_clks);
    check((tc - mon_start) == 10 * bit_clks, "R6", "start-to-ti distance",
          tc - mon_start, 10 * bit_clks);
    repeat (bit_clks / 2 + 2) @(negedge clk);
    if (do_clear) clear_ti();
  endtask

  initial begin
    rst_n = 1'b1; fixed_rate = 1'b1; rate_sel = 1'b1;
    wr_en = 1'b0; wr_data = '0; wr_ninth = 1'b0; ti_clr = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R9", "txd in reset", txd, 1);
    check(ti == 1'b0, "R9", "ti in reset", ti, 0);
    check(sending == 1'b0, "R9", "sending in reset", sending, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_done = 1;
    check(txd == 1'b1 && !sending, "R2", "idle line after reset", txd, 1);

    // R4: fast internal rate, several data patterns.
    bit_clks = 32; align_ok = 0;
    send_frame(8'hA5, 1'b1, 1'b1);
    send_frame(8'h3C, 1'b0, 1'b1);
    send_frame(8'h02, 1'b0, 1'b1);   // raw contents resemble end pattern
    send_frame(8'hFF, 1'b1, 1'b1);
    send_frame(8'h00, 1'b0, 1'b1);
    send_frame(8'h81, 1'b1, 1'b1);

    // R7: flag holds without a clear.
    send_frame(8'h5A, 1'b0, 1'b0);
    repeat (3 * bit_clks) @(negedge clk);
    check(ti == 1'b1, "R7", "ti held without clear", ti, 1);
    check(txd == 1'b1, "R2", "line high between frames", txd, 1);
    clear_ti();

    // R8: writes while pending and while in flight are ignored.
    begin
      int tc;
      exp_q.push_back({1'b1, 8'hC3});
      pulse_wr(8'hC3, 1'b1);
      pulse_wr(8'h18, 1'b0);          // pending: ignored
      while (!sending) @(negedge clk);
      repeat (3 * bit_clks + 5) @(negedge clk);
      pulse_wr(8'h7E, 1'b0);          // in flight: ignored
      while (!ti) @(negedge clk);
      tc = cyc;
      check((tc - mon_start) == 10 * bit_clks, "R8", "in-flight frame length",
            tc - mon_start, 10 * bit_clks);
      repeat (bit_clks / 2 + 2) @(negedge clk);
      clear_ti();
      repeat (3 * bit_clks) @(negedge clk);
      check(txd == 1'b1 && !sending, "R8", "no frame after ignored writes", txd, 1);
      check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
    end

    // R4: slow internal rate.
    rate_sel = 1'b0; bit_clks = 64; align_ok = 0;
    repeat (8) @(negedge clk);
    send_frame(8'h96, 1'b1, 1'b1);
    send_frame(8'h01, 1'b0, 1'b1);

    // R5: external tick, 3 clocks per tick -> 48 clocks per bit.
    fixed_rate = 1'b0; ext_on = 1; ext_div = 3; bit_clks = 48; align_ok = 0;
    repeat (8) @(negedge clk);
    send_frame(8'h6B, 1'b0, 1'b1);
    send_frame(8'hE4, 1'b1, 1'b1);

    repeat (2 * bit_clks) @(negedge clk);
    check(exp_q.size() == 0, "R1", "all expected frames seen", exp_q.size(), 0);
    finish_run();
  end
endmodule